// File: doc/BRIEF.md
# Predicated Packed SIMD Adder

This block adds two packed 32-bit operands as four independent 8-bit lanes. Each lane is gated by predication before it is written back. A mode input selects how the predicate applies. In per-lane mode, each lane follows its own predicate bit, and an end-of-vector lane count also switches off the lanes past the tail. In whole-block mode, one predicate bit enables or disables the entire packed word, and the count is ignored.

A lane that is switched off either returns zero or passes through the old destination lane, as the zeroing flag selects. The result is registered together with a per-lane write-enable mask, so a register file downstream can merge or skip each lane. The block has one cycle of latency, and a valid strobe travels alongside the data.

Top module: `pred_simd_add`

## Requirements
- R1: Lane i occupies bits 8i+7..8i of each packed word. An enabled lane outputs (opa lane + opb lane) mod 256, and no carry crosses into the next lane.
- R2: With lane_mode_i=1 (per-lane mode), lane i is enabled only when pred_i[i]=1 and i < vlen_i.
- R3: With lane_mode_i=0 (whole-block mode), all four lanes are enabled when pred_i[0]=1 and all are disabled when pred_i[0]=0. pred_i[3:1] has no effect in this mode.
- R4: vlen_i limits lanes only in per-lane mode, and values 5 to 7 act as 4. In whole-block mode vlen_i has no effect.
- R5: wen_o bit i is 1 exactly when lane i was enabled, for the operation reported in that cycle.
- R6: A disabled lane outputs 0 when zero_i=1. When zero_i=0 it outputs the matching lane of dst_old_i.
- R7: result_o, wen_o and valid_o present an operation on the cycle after the rising edge that samples valid_i=1.
- R8: After an edge that samples valid_i=0, valid_o=0 and wen_o=0, and result_o keeps its previous value.
- R9: While rst_ni is low, valid_o, wen_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present |
| opa_i | input | 32 | Packed operand A |
| opb_i | input | 32 | Packed operand B |
| dst_old_i | input | 32 | Previous destination value |
| pred_i | input | 4 | Predicate bits, one per lane |
| lane_mode_i | input | 1 | 1 = per-lane predication, 0 = whole-block |
| zero_i | input | 1 | Zero the disabled lanes instead of keeping the old value |
| vlen_i | input | 3 | End-of-vector lane count |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Packed result |
| wen_o | output | 4 | Per-lane write enable |

## Verification
The bench sweeps every combination of mode, zeroing flag, predicate and count, including the count codes above four. It does this under operand patterns chosen so that lane sums overflow. A design that leaked carries between lanes would corrupt the neighbouring lane wherever a lane wraps. Applying the count in whole-block mode would clear lanes that should be written. Reading pred_i[3:1] in whole-block mode would split the block into partial writes. Mishandling counts of 5 to 7 would drop tail lanes or enable no lanes at all. Idle cycles check that the write enables fall and that the result holds its last value.

// File: rtl/pred_simd_pkg.sv
package pred_simd_pkg;
  typedef enum logic {
    PRED_WHOLE = 1'b0,
    PRED_LANE  = 1'b1
  } pred_mode_e;
endpackage

// File: rtl/pred_simd_mask.sv
module pred_simd_mask
  import pred_simd_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 3
) (
  input  logic [LANES-1:0] pred_i,
  input  logic             lane_mode_i,
  input  logic [CNT_W-1:0] vlen_i,
  output logic [LANES-1:0] en_o
);
  pred_mode_e mode;
  assign mode = pred_mode_e'(lane_mode_i);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_vec;
    assign in_vec = 32'(vlen_i) > i;
    always_comb begin
      if (mode == PRED_LANE) en_o[i] = pred_i[i] & in_vec;
      else                   en_o[i] = pred_i[0];
    end
  end
endmodule

// File: rtl/pred_simd_lane.sv
module pred_simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] old_i,
  input  logic         en_i,
  input  logic         zero_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] sum;
  assign sum = a_i + b_i;  // wraps mod 2^W

  always_comb begin
    if (en_i)        res_o = sum;
    else if (zero_i) res_o = '0;
    else             res_o = old_i;
  end
endmodule

// File: rtl/pred_simd_add.sv
module pred_simd_add #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [DW-1:0]    opa_i,
  input  logic [DW-1:0]    opb_i,
  input  logic [DW-1:0]    dst_old_i,
  input  logic [LANES-1:0] pred_i,
  input  logic             lane_mode_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] vlen_i,
  output logic             valid_o,
  output logic [DW-1:0]    result_o,
  output logic [LANES-1:0] wen_o
);
  logic [LANES-1:0] en;
  logic [DW-1:0]    res_d;

  pred_simd_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
    .pred_i      (pred_i),
    .lane_mode_i (lane_mode_i),
    .vlen_i      (vlen_i),
    .en_o        (en)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pred_simd_lane #(.W(LANE_W)) u_lane (
      .a_i    (opa_i[i*LANE_W +: LANE_W]),
      .b_i    (opb_i[i*LANE_W +: LANE_W]),
      .old_i  (dst_old_i[i*LANE_W +: LANE_W]),
      .en_i   (en[i]),
      .zero_i (zero_i),
      .res_o  (res_d[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wen_o    <= '0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      wen_o   <= valid_i ? en : '0;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/pred_simd_add_chk.sv
module pred_simd_add_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [DW-1:0]    opa_i,
  input logic [DW-1:0]    opb_i,
  input logic [DW-1:0]    dst_old_i,
  input logic [LANES-1:0] pred_i,
  input logic             lane_mode_i,
  input logic             zero_i,
  input logic [CNT_W-1:0] vlen_i,
  input logic             valid_o,
  input logic [DW-1:0]    result_o,
  input logic [LANES-1:0] wen_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R7
  AST_IDLE_NO_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && wen_o == '0 && $stable(result_o))); // R8
  AST_WHOLE_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !lane_mode_i) |=> (wen_o == '0 || wen_o == '1)); // R3
  AST_PRED_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lane_mode_i) |=> ((wen_o & ~$past(pred_i)) == '0)); // R2
  AST_EMPTY_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lane_mode_i && vlen_i == '0) |=> (wen_o == '0)); // R4

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    AST_LANE_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (!wen_o[i] || result_o[i*LANE_W +: LANE_W] ==
        LANE_W'($past(opa_i[i*LANE_W +: LANE_W]) + $past(opb_i[i*LANE_W +: LANE_W])))); // R1
    AST_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && zero_i) |=> (wen_o[i] || result_o[i*LANE_W +: LANE_W] == '0)); // R6
    AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !zero_i) |=> (wen_o[i] ||
        result_o[i*LANE_W +: LANE_W] == $past(dst_old_i[i*LANE_W +: LANE_W]))); // R6
  end
endmodule

bind pred_simd_add pred_simd_add_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/pred_simd_add_bench.sv
`timescale 1ns/1ps
module pred_simd_add_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0, dst_old_i = '0;
  logic [3:0]  pred_i = '0;
  logic        lane_mode_i = 1'b0, zero_i = 1'b0;
  logic [2:0]  vlen_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  wen_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pred_simd_add u_pred_simd_add (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_en(input logic mode, input logic [3:0] p,
                                        input logic [2:0] n);
    logic [3:0] e;
    for (int i = 0; i < 4; i++)
      e[i] = mode ? (p[i] && (int'(n) > i)) : p[0];
    return e;
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] old, input logic [3:0] p,
                        input logic mode, input logic z, input logic [2:0] n);
    logic [3:0]  e;
    logic [31:0] r;
    string       wt, rt;
    @(negedge clk_i);
    valid_i = 1'b1; opa_i = a; opb_i = b; dst_old_i = old;
    pred_i = p; lane_mode_i = mode; zero_i = z; vlen_i = n;
    e = exp_en(mode, p, n);
    for (int i = 0; i < 4; i++) begin
      int s;
      s = (int'(a[i*8 +: 8]) + int'(b[i*8 +: 8])) % 256;
      r[i*8 +: 8] = e[i] ? 8'(s) : (z ? 8'h00 : old[i*8 +: 8]);
    end
    wt = !mode ? "R3" : (n < 4 ? "R4" : "R2");
    rt = (e == 4'hF) ? "R1" : "R6";
    @(negedge clk_i);
    check(valid_o === 1'b1, "R7", {31'b0, valid_o}, 32'd1);
    check(wen_o === e, {wt, "/R5"}, {28'b0, wen_o}, {28'b0, e});
    check(result_o === r, rt, result_o, r);
  endtask

  initial begin
    logic [31:0] held;
    #1;
    check(valid_o === 1'b0 && wen_o === 4'h0 && result_o === 32'h0, "R9",
          result_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int pat = 0; pat < 3; pat++) begin
      logic [31:0] a, b, o;
      case (pat)
        0: begin a = 32'hFF80_7F01; b = 32'h0180_81FF; o = 32'hA5C3_5A3C; end
        1: begin a = 32'h1234_5678; b = 32'h1111_1111; o = 32'hDEAD_BEEF; end
        default: begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; o = 32'h0102_0304; end
      endcase
      for (int m = 0; m < 2; m++)
        for (int z = 0; z < 2; z++)
          for (int n = 0; n < 8; n++)
            for (int p = 0; p < 16; p++)
              run_op(a, b, o, 4'(p), 1'(m), 1'(z), 3'(n));
    end
    held = result_o;
    @(negedge clk_i);
    valid_i = 1'b0;
    opa_i = 32'h5555_5555;
    pred_i = 4'hF;
    @(negedge clk_i);
    check(valid_o === 1'b0, "R8", {31'b0, valid_o}, 32'd0);
    check(wen_o === 4'h0, "R8", {28'b0, wen_o}, 32'd0);
    check(result_o === held, "R8", result_o, held);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule